// File: doc/BRIEF.md
# Receive DMA Buffer Writer with Timestamp Writeback

This block takes one received frame as a stream of bytes and stores it into memory buffers that software describes with descriptors. Each descriptor offers an ownership flag, a 32-bit buffer pointer and a buffer length in bytes. The block turns the byte stream into word-wide memory writes with per-byte strobes. The write address is always word aligned. For the buffer that opens a frame, the frame bytes are shifted into the lane picked by the low pointer bits. A frame ends on the byte marked with the end marker, and the next accepted byte opens a new frame.

When a buffer fills before the frame ends, the block hands that descriptor back and asks for another one. The frame then continues in the new buffer from lane 0, and the low pointer bits of that buffer are ignored. At the end of the frame the block can overwrite the pointer word of the descriptor with the low 32 bits of the frame timestamp. Only after that does it write the control word with the ownership flag cleared.

The controller is a four-state machine:
- `ST_IDLE` asks for a descriptor. It goes to `ST_FILL` when the descriptor is owned, and it stays in `ST_IDLE` with a "descriptor unavailable" pulse when the descriptor is not owned.
- `ST_FILL` accepts bytes. It goes to `ST_WB_TS` on the end byte when timestamping is on. It goes to `ST_WB_CTL` on the end byte when timestamping is off, or when the buffer becomes full.
- `ST_WB_TS` writes descriptor word 2 and always moves on to `ST_WB_CTL`.
- `ST_WB_CTL` writes descriptor word 0 and always returns to `ST_IDLE`.

Top module: `rxw_dma_writer`

## Requirements
- R1: After reset `in_ready`, `mem_we` and `wb_we` are 0 and `desc_req` is 1.
- R2: A descriptor presented with `desc_own` = 0 gives `desc_unavail` = 1 in that cycle. `in_ready` stays 0 and no memory write or writeback follows, and `desc_req` stays 1.
- R3: Memory writes use the buffer pointer with bits 1:0 cleared, and the address rises by 4 for each further word of the same buffer.
- R4: In the buffer that opens a frame, the first byte goes to lane `ptr[1:0]`, and the strobe bits of the lanes below it are 0. Byte lane k is `mem_data[8k+7:8k]` with strobe bit k.
- R5: The word holding the last byte of a buffer has strobe 0 for the lanes above that byte. Lanes with strobe 0 carry data 0.
- R6: If the buffer fills before the end byte, the block writes word 0 with LS = 0 and no timestamp, requests a new descriptor, and continues in it from lane 0 at `ptr & ~3`. When the end byte is also the byte that fills the buffer, it counts as end of frame (LS = 1).
- R7: When `ts_en` is 1 at the end byte, `ts_val` sampled with that byte is written to word 2 (`wb_word` = 2). This write happens in the cycle right before the word-0 write.
- R8: When `ts_en` is 0 at the end byte, only word 0 is written back, and word 2 keeps the pointer.
- R9: The word-0 writeback has bit 31 (owner) = 0, bit 9 = first buffer of frame, bit 8 = last buffer of frame (LS), bit 7 = timestamp written, and all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_req | output | 1 | Block is waiting for a descriptor |
| desc_valid | input | 1 | Descriptor fields are presented this cycle |
| desc_own | input | 1 | Ownership flag of the presented descriptor (1 = block may use it) |
| desc_ptr | input | 32 | Buffer pointer (descriptor word 2 on entry) |
| desc_len | input | 13 | Buffer length in bytes, at least 1 |
| desc_unavail | output | 1 | Pulse: presented descriptor not owned |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Frame byte |
| in_eof | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| ts_en | input | 1 | Timestamping on for the current frame, sampled with the end byte |
| ts_val | input | 32 | Low 32 bits of the frame timestamp, sampled with the end byte |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_data | output | 32 | Write data |
| mem_strb | output | 4 | Per-byte write enables |
| wb_we | output | 1 | Descriptor writeback strobe |
| wb_word | output | 2 | Descriptor word index written (0 or 2) |
| wb_data | output | 32 | Descriptor writeback data |

## Verification
The bench checks a start at offset 3 with a single-byte frame. A design that ignores the pointer offset would write lane 0, and one with wrong strobe masking would enable lanes it never filled. A frame split across two buffers, where the second pointer has nonzero low bits, shows whether the design wrongly applies that offset again or puts a timestamp on the non-final descriptor. A frame whose end byte exactly fills its buffer shows whether buffer-full wins over end of frame, which would drop LS and ask for a needless descriptor. An unowned descriptor shows whether the design writes into a buffer it does not own, and the timestamp-off case catches a stray word-2 overwrite.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_WB_TS,
        ST_WB_CTL
    } rxw_state_e;

    localparam int OWN_BIT = 31;
    localparam int FS_BIT  = 9;
    localparam int LS_BIT  = 8;
    localparam int TSV_BIT = 7;

    localparam logic [1:0] WORD_CTL = 2'd0;
    localparam logic [1:0] WORD_PTR = 2'd2;
endpackage

// File: rtl/rxw_packer.sv
module rxw_packer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              load,
    input  logic [ADDR_W-1:0]                 load_addr,
    input  logic [$clog2(DATA_W/8)-1:0]       load_lane,
    input  logic                              push,
    input  logic [7:0]                        push_byte,
    input  logic                              flush,
    output logic                              mem_we,
    output logic [ADDR_W-1:0]                 mem_addr,
    output logic [DATA_W-1:0]                 mem_data,
    output logic [DATA_W/8-1:0]               mem_strb
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0]  lane_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] acc_d, nxt_d;
    logic [LANES-1:0]  acc_s, nxt_s;
    logic              emit;

    always_comb begin
        nxt_d = acc_d;
        nxt_d[{lane_q, 3'b000} +: 8] = push_byte;
        nxt_s = acc_s | (LANES'(1) << lane_q);
        emit  = push && ((lane_q == OFF_W'(LANES - 1)) || flush);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q   <= '0;
            addr_q   <= '0;
            acc_d    <= '0;
            acc_s    <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_strb <= '0;
        end else begin
            mem_we <= 1'b0;
            if (load) begin
                lane_q <= load_lane;
                addr_q <= {load_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                acc_d  <= '0;
                acc_s  <= '0;
            end else if (push) begin
                if (emit) begin
                    mem_we   <= 1'b1;
                    mem_addr <= addr_q;
                    mem_data <= nxt_d;
                    mem_strb <= nxt_s;
                    addr_q   <= addr_q + ADDR_W'(LANES);
                    lane_q   <= '0;
                    acc_d    <= '0;
                    acc_s    <= '0;
                end else begin
                    acc_d  <= nxt_d;
                    acc_s  <= nxt_s;
                    lane_q <= lane_q + 1'b1;
                end
            end
        end
    end

    // R3: every memory write is word aligned
    p_addr_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[OFF_W-1:0] == '0));

    // R5: a write always enables at least one lane
    p_strb_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_strb != '0));

    // R4: a byte pushed into the top lane completes a word on the next cycle
    p_top_lane_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load && lane_q == OFF_W'(LANES - 1)) |=> (mem_we && mem_strb[LANES-1]));
endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
    import rxw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic              desc_own,
    input  logic [ADDR_W-1:0] desc_ptr,
    input  logic [LEN_W-1:0]  desc_len,
    output logic              desc_req,
    output logic              desc_unavail,
    input  logic              in_valid,
    input  logic              in_eof,
    output logic              in_ready,
    input  logic              ts_en,
    input  logic [31:0]       ts_val,
    output logic              pk_load,
    output logic [ADDR_W-1:0] pk_addr,
    output logic [OFF_W-1:0]  pk_lane,
    output logic              pk_push,
    output logic              pk_flush,
    output logic              wb_we,
    output logic [1:0]        wb_word,
    output logic [31:0]       wb_data
);
    rxw_state_e state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic             first_q, fs_pend_q, ls_q, tsv_q;
    logic [31:0]      ts_q;
    logic             take_desc, take_byte, buf_full;

    assign take_desc = (state_q == ST_IDLE) && desc_valid && desc_own;
    assign take_byte = (state_q == ST_FILL) && in_valid;
    assign buf_full  = (rem_q == LEN_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_desc) state_d = ST_FILL;
            ST_FILL: begin
                if (take_byte && in_eof)
                    state_d = ts_en ? ST_WB_TS : ST_WB_CTL;
                else if (take_byte && buf_full)
                    state_d = ST_WB_CTL;
            end
            ST_WB_TS:  state_d = ST_WB_CTL;
            ST_WB_CTL: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            first_q   <= 1'b0;
            fs_pend_q <= 1'b1;
            ls_q      <= 1'b0;
            tsv_q     <= 1'b0;
            ts_q      <= '0;
        end else begin
            state_q <= state_d;
            if (take_desc) begin
                rem_q   <= desc_len;
                first_q <= fs_pend_q;
            end
            if (take_byte) begin
                rem_q <= rem_q - LEN_W'(1);
                if (in_eof) begin
                    ls_q      <= 1'b1;
                    tsv_q     <= ts_en;
                    ts_q      <= ts_val;
                    fs_pend_q <= 1'b1;
                end else if (buf_full) begin
                    ls_q      <= 1'b0;
                    tsv_q     <= 1'b0;
                    fs_pend_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        desc_req     = 1'b0;
        desc_unavail = 1'b0;
        in_ready     = 1'b0;
        pk_load      = 1'b0;
        pk_addr      = desc_ptr;
        pk_lane      = '0;
        pk_push      = 1'b0;
        pk_flush     = 1'b0;
        wb_we        = 1'b0;
        wb_word      = WORD_CTL;
        wb_data      = '0;
        unique case (state_q)
            ST_IDLE: begin
                desc_req     = 1'b1;
                desc_unavail = desc_valid && !desc_own;
                pk_load      = take_desc;
                pk_lane      = fs_pend_q ? desc_ptr[OFF_W-1:0] : '0;
            end
            ST_FILL: begin
                in_ready = 1'b1;
                pk_push  = in_valid;
                pk_flush = in_eof || buf_full;
            end
            ST_WB_TS: begin
                wb_we   = 1'b1;
                wb_word = WORD_PTR;
                wb_data = ts_q;
            end
            ST_WB_CTL: begin
                wb_we            = 1'b1;
                wb_word          = WORD_CTL;
                wb_data[OWN_BIT] = 1'b0;
                wb_data[FS_BIT]  = first_q;
                wb_data[LS_BIT]  = ls_q;
                wb_data[TSV_BIT] = tsv_q;
            end
            default: ;
        endcase
    end

    // R7: owner is released only after the timestamp word went out
    p_ts_before_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_word == WORD_CTL && wb_data[TSV_BIT]) |->
            $past(wb_we && wb_word == WORD_PTR));

    // R6: a timestamp write is always followed by a last-segment control word
    p_ts_only_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_word == WORD_PTR) |=> (wb_we && wb_word == WORD_CTL && wb_data[LS_BIT]));

    // R2: an unowned descriptor stalls input and causes no writeback
    p_stall_unavail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_unavail |-> (!in_ready && !wb_we && desc_req));

    // R2: after an unowned descriptor the block is still asking for one
    p_still_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_unavail |=> (desc_req && !wb_we));
endmodule

// File: rtl/rxw_dma_writer.sv
module rxw_dma_writer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic                desc_req,
    input  logic                desc_valid,
    input  logic                desc_own,
    input  logic [ADDR_W-1:0]   desc_ptr,
    input  logic [LEN_W-1:0]    desc_len,
    output logic                desc_unavail,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_eof,
    output logic                in_ready,
    input  logic                ts_en,
    input  logic [31:0]         ts_val,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_data,
    output logic [DATA_W/8-1:0] mem_strb,
    output logic                wb_we,
    output logic [1:0]          wb_word,
    output logic [31:0]         wb_data
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic              pk_load, pk_push, pk_flush;
    logic [ADDR_W-1:0] pk_addr;
    logic [OFF_W-1:0]  pk_lane;

    rxw_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .OFF_W  (OFF_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_own     (desc_own),
        .desc_ptr     (desc_ptr),
        .desc_len     (desc_len),
        .desc_req     (desc_req),
        .desc_unavail (desc_unavail),
        .in_valid     (in_valid),
        .in_eof       (in_eof),
        .in_ready     (in_ready),
        .ts_en        (ts_en),
        .ts_val       (ts_val),
        .pk_load      (pk_load),
        .pk_addr      (pk_addr),
        .pk_lane      (pk_lane),
        .pk_push      (pk_push),
        .pk_flush     (pk_flush),
        .wb_we        (wb_we),
        .wb_word      (wb_word),
        .wb_data      (wb_data)
    );

    rxw_packer #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pk_load),
        .load_addr (pk_addr),
        .load_lane (pk_lane),
        .push      (pk_push),
        .push_byte (in_data),
        .flush     (pk_flush),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_strb  (mem_strb)
    );
endmodule

// File: tb/tb_rxw_dma_writer.sv
module tb_rxw_dma_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_req, desc_valid, desc_own, desc_unavail;
    logic [31:0] desc_ptr;
    logic [12:0] desc_len;
    logic        in_valid, in_eof, in_ready, ts_en;
    logic [7:0]  in_data;
    logic [31:0] ts_val;
    logic        mem_we, wb_we;
    logic [31:0] mem_addr, mem_data, wb_data;
    logic [3:0]  mem_strb;
    logic [1:0]  wb_word;

    always #10 clk = ~clk;

    rxw_dma_writer dut (
        .clk(clk), .rst_n(rst_n), .desc_req(desc_req), .desc_valid(desc_valid),
        .desc_own(desc_own), .desc_ptr(desc_ptr), .desc_len(desc_len),
        .desc_unavail(desc_unavail), .in_valid(in_valid), .in_data(in_data),
        .in_eof(in_eof), .in_ready(in_ready), .ts_en(ts_en), .ts_val(ts_val),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_strb(mem_strb), .wb_we(wb_we), .wb_word(wb_word), .wb_data(wb_data)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] em_addr_q[$];
    logic [31:0] em_data_q[$];
    logic [3:0]  em_strb_q[$];
    string       em_tag_q[$];
    logic [1:0]  ew_word_q[$];
    logic [31:0] ew_data_q[$];
    string       ew_tag_q[$];

    logic [31:0] dptr[4];
    logic [12:0] dlen[4];

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected items as the design writes
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (em_addr_q.size() == 0) begin
                check(1'b0, "R3 unexpected memory write", {mem_addr, mem_data}, 64'h0);
            end else begin
                logic [31:0] ea, ed;
                logic [3:0]  es;
                string       et;
                ea = em_addr_q.pop_front();
                ed = em_data_q.pop_front();
                es = em_strb_q.pop_front();
                et = em_tag_q.pop_front();
                check(mem_addr == ea && mem_data == ed && mem_strb == es, et,
                      {mem_addr[27:0], mem_strb, mem_data}, {ea[27:0], es, ed});
            end
        end
        if (rst_n && wb_we) begin
            if (ew_word_q.size() == 0) begin
                check(1'b0, "R8 unexpected writeback", {30'h0, wb_word, wb_data}, 64'h0);
            end else begin
                logic [1:0]  ewd;
                logic [31:0] edt;
                string       et;
                ewd = ew_word_q.pop_front();
                edt = ew_data_q.pop_front();
                et  = ew_tag_q.pop_front();
                check(wb_word == ewd && wb_data == edt, et,
                      {30'h0, wb_word, wb_data}, {30'h0, ewd, edt});
            end
        end
    end

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'(seed * 17 + i * 5 + 1);
    endfunction

    task automatic run_frame(input int n, input int seed, input bit ten,
                             input logic [31:0] tsv, input int ndesc);
        int j = 0;
        int lane = int'(dptr[0][1:0]);
        logic [31:0] addr = dptr[0] & ~32'h3;
        int rem = int'(dlen[0]);
        logic [31:0] word = '0;
        logic [3:0]  strb = '0;
        bit firstword = 1'b1;
        for (int i = 0; i < n; i++) begin
            bit last, full;
            word[lane*8 +: 8] = fbyte(seed, i);
            strb[lane] = 1'b1;
            rem--;
            last = (i == n - 1);
            full = (rem == 0);
            if (lane == 3 || last || full) begin
                em_addr_q.push_back(addr);
                em_data_q.push_back(word);
                em_strb_q.push_back(strb);
                if (firstword && j == 0 && dptr[0][1:0] != 0) em_tag_q.push_back("R4 offset start");
                else if (last || full) em_tag_q.push_back("R5 final word strobes");
                else if (j > 0) em_tag_q.push_back("R6 continuation lane 0");
                else em_tag_q.push_back("R3 aligned word");
                firstword = 1'b0;
                addr += 4;
                lane = 0;
                word = '0;
                strb = '0;
            end else begin
                lane++;
            end
            if (last || full) begin
                logic [31:0] w0 = '0;
                if (last && ten) begin
                    ew_word_q.push_back(2'd2);
                    ew_data_q.push_back(tsv);
                    ew_tag_q.push_back("R7 timestamp word");
                end
                w0[9] = (j == 0);
                w0[8] = last;
                w0[7] = last && ten;
                ew_word_q.push_back(2'd0);
                ew_data_q.push_back(w0);
                if (!last) ew_tag_q.push_back("R6 non-last control word");
                else if (!ten) ew_tag_q.push_back("R8 control word no ts");
                else ew_tag_q.push_back("R9 control word");
                if (!last) begin
                    j++;
                    lane = 0;
                    addr = dptr[j] & ~32'h3;
                    rem = int'(dlen[j]);
                end
            end
        end
        ts_en  = ten;
        ts_val = tsv;
        fork
            begin
                for (int d = 0; d < ndesc; d++) begin
                    while (!desc_req) @(negedge clk);
                    desc_valid = 1'b1;
                    desc_own   = 1'b1;
                    desc_ptr   = dptr[d];
                    desc_len   = dlen[d];
                    @(negedge clk);
                    desc_valid = 1'b0;
                end
            end
            begin
                for (int i = 0; i < n; i++) begin
                    in_valid = 1'b1;
                    in_data  = fbyte(seed, i);
                    in_eof   = (i == n - 1);
                    while (!in_ready) @(negedge clk);
                    @(negedge clk);
                end
                in_valid = 1'b0;
                in_eof   = 1'b0;
            end
        join
        repeat (6) @(negedge clk);
        check(em_addr_q.size() == 0 && ew_word_q.size() == 0, "R3 R9 all writes seen",
              64'(em_addr_q.size() + ew_word_q.size()), 64'h0);
    endtask

    bit done = 1'b0;

    initial begin
        desc_valid = 0; desc_own = 0; desc_ptr = 0; desc_len = 0;
        in_valid = 0; in_data = 0; in_eof = 0; ts_en = 0; ts_val = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!in_ready && !mem_we && !wb_we && desc_req, "R1 reset state",
              {60'h0, in_ready, mem_we, wb_we, desc_req}, 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_ready && desc_req, "R1 after reset", {62'h0, in_ready, desc_req}, 64'h1);

        // R2 unowned descriptor with bytes waiting
        desc_valid = 1'b1; desc_own = 1'b0; desc_ptr = 32'h0000_7000; desc_len = 13'd16;
        in_valid = 1'b1; in_data = 8'hAA;
        #1;
        check(desc_unavail && !in_ready, "R2 unavailable pulse and stall",
              {62'h0, desc_unavail, in_ready}, 64'h2);
        @(negedge clk);
        desc_valid = 1'b0;
        check(!mem_we && !wb_we && desc_req && !in_ready, "R2 no write after unowned",
              {60'h0, mem_we, wb_we, desc_req, in_ready}, 64'h2);
        @(negedge clk);
        check(!mem_we && !wb_we && !desc_unavail, "R2 still idle",
              {61'h0, mem_we, wb_we, desc_unavail}, 64'h0);
        in_valid = 1'b0;

        // aligned, timestamp on (R3 R7 R9)
        dptr[0] = 32'h0000_1000; dlen[0] = 13'd64;
        run_frame(10, 1, 1'b1, 32'hCAFE_0001, 1);
        // unaligned start, timestamp off (R4 R5 R8)
        dptr[0] = 32'h0000_2003; dlen[0] = 13'd64;
        run_frame(9, 2, 1'b0, 32'h1234_5678, 1);
        // split over two buffers, second pointer unaligned (R6 R7)
        dptr[0] = 32'h0000_3002; dlen[0] = 13'd5;
        dptr[1] = 32'h0000_4001; dlen[1] = 13'd64;
        run_frame(12, 3, 1'b1, 32'hBEEF_0003, 2);
        // end byte fills the buffer exactly (R6 LS priority)
        dptr[0] = 32'h0000_5000; dlen[0] = 13'd8;
        run_frame(8, 4, 1'b1, 32'h0BAD_0004, 1);
        // one-byte frame at top lane (R4 R5)
        dptr[0] = 32'h0000_6003; dlen[0] = 13'd32;
        run_frame(1, 5, 1'b0, 32'h0, 1);
        // three buffers, timestamp off (R6 R8)
        dptr[0] = 32'h0000_8001; dlen[0] = 13'd3;
        dptr[1] = 32'h0000_9002; dlen[1] = 13'd4;
        dptr[2] = 32'h0000_A003; dlen[2] = 13'd16;
        run_frame(10, 6, 1'b0, 32'h0, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule